// File: doc/BRIEF.md
# Two-Channel Address Protection Trap Unit

This block checks every memory access address against two compare channels. Each channel holds a base and a mask. A channel hits when the masked access address equals the masked base. The two hits are combined into a protection exception request. In normal mode any hit raises the request. In invert mode only a hit on exactly one channel raises it, so one channel can open a non-trapping hole inside the region that the other channel traps.

A control/status word holds the master enable, the invert-mode bit and two sticky status bits. The status bits record which channels hit on the most recent qualifying violation, and software clears them by writing 0. The request is combinational and is valid in the same cycle as the access strobe. It comes with a one-bit cause that separates store violations from fetch and load violations. A concurrent non-maskable interrupt or bus-error event blocks the request but does not block the status capture.

Top module: `prot_trap_unit`

## Requirements
- R1: After reset the enable bit, the invert bit and both status bits are 0, and every base and mask register reads 0.
- R2: Channel c hits when `(acc_addr & mask_c) == (base_c & mask_c)`. A mask of 0 therefore matches every address.
- R3: With invert mode 0, a qualifying access raises `trap_req` when channel 0 hits, channel 1 hits, or both hit.
- R4: With invert mode 1, `trap_req` is raised only when exactly one channel hits. When both channels hit, there is no request and the status is not updated.
- R5: While the enable bit is 0, `trap_req` stays 0 and the status bits keep their value, whatever the accesses.
- R6: A violation (valid access, enable 1, combined hit true) loads the status with {channel 1 hit, channel 0 hit} at the next clock edge. A channel that did not hit is loaded as 0.
- R7: A write to the control word ANDs each status bit with the written bit, so writing 1 leaves the bit unchanged. If a violation occurs in the same cycle as the write, the hardware capture wins.
- R8: `trap_cause` is 1 for a store (`acc_kind` = 2'b10) and 0 for an instruction fetch (2'b00) or a data load (2'b01, or 2'b11). It is 0 whenever `trap_req` is 0.
- R9: When `nmi_evt` or `bus_err_evt` is high, `trap_req` is 0, but a violation still updates the status as in R6.
- R10: The register offsets are: 0 = control/status (invert at bit 9, enable at bit 8, status at bits 1:0, every other bit reads 0), 1 = base 0, 2 = mask 0, 3 = base 1, 4 = mask 1. Offsets 5 to 7 read 0 and ignore writes.
- R11: `trap_req` is 0 whenever `acc_valid` is 0. When it is raised, it is valid in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| nmi_evt | input | 1 | Concurrent non-maskable interrupt |
| bus_err_evt | input | 1 | Concurrent bus error |
| trap_req | output | 1 | Protection exception request |
| trap_cause | output | 1 | 1 = store violation, 0 = fetch/load violation |

## Verification
The bench places a small channel-1 region inside a wider channel-0 region and steps addresses through both regions and outside them, in both modes. A design that used OR in invert mode would trap inside the hole, and one that captured status on a double hit in invert mode would overwrite the status with 11. Writes to the control word that coincide with a violation are targeted directly: a design that let the software clear win would lose the capture, and one that wrote the status bits directly would set bits that are meant to be sticky. Accesses under a non-maskable interrupt or bus error check that the request is dropped while the status still updates, and accesses with the enable off check that the status does not move.

// File: rtl/prot_trap_unit.sv
`timescale 1ns/1ps
module prot_trap_unit #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [SW-1:0] reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          nmi_evt,
  input  logic          bus_err_evt,
  output logic          trap_req,
  output logic          trap_cause
);
  localparam int NCH = 2;
  localparam logic [SW-1:0] SEL_CTRL = '0;
  localparam int BIT_INV = 9;
  localparam int BIT_EN  = 8;
  localparam logic [1:0] KIND_STORE = 2'b10;

  logic [AW-1:0]  base_q [NCH];
  logic [AW-1:0]  mask_q [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] st_q;
  logic           en_q, inv_q;
  logic           comb_hit, fire, ctrl_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [SW-1:0] SEL_BASE = SW'(1 + 2*c);
    localparam logic [SW-1:0] SEL_MASK = SW'(2 + 2*c);
    assign hit[c] = ((acc_addr ^ base_q[c]) & mask_q[c]) == '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[c] <= '0;
        mask_q[c] <= '0;
      end else if (reg_we) begin
        if (reg_sel == SEL_BASE) base_q[c] <= reg_wdata;
        if (reg_sel == SEL_MASK) mask_q[c] <= reg_wdata;
      end
    end
  end

  assign comb_hit   = inv_q ? ^hit : |hit;
  assign fire       = acc_valid & en_q & comb_hit;
  assign trap_req   = fire & ~nmi_evt & ~bus_err_evt;
  assign trap_cause = trap_req & (acc_kind == KIND_STORE);
  assign ctrl_wr    = reg_we & (reg_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
      st_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[BIT_EN];
        inv_q <= reg_wdata[BIT_INV];
        st_q  <= st_q & reg_wdata[NCH-1:0];
      end
      if (fire) st_q <= hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[BIT_INV]   = inv_q;
        reg_rdata[BIT_EN]    = en_q;
        reg_rdata[NCH-1:0]   = st_q;
      end
      SW'(1):  reg_rdata = base_q[0];
      SW'(2):  reg_rdata = mask_q[0];
      SW'(3):  reg_rdata = base_q[1];
      SW'(4):  reg_rdata = mask_q[1];
      default: reg_rdata = '0;
    endcase
  end
endmodule

module prot_trap_unit_chk #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [SW-1:0] reg_sel,
  input logic          acc_valid,
  input logic [1:0]    acc_kind,
  input logic          nmi_evt,
  input logic          bus_err_evt,
  input logic          trap_req,
  input logic          trap_cause,
  input logic          en_q,
  input logic          inv_q,
  input logic [1:0]    st_q,
  input logic [1:0]    hit
);
  p_req_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> acc_valid);
  p_req_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> en_q);
  p_status_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(reg_we && reg_sel == '0)) |=> $stable(st_q));
  p_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && hit == 2'b11) |-> !trap_req);
  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt || bus_err_evt) |-> !trap_req);
  p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause == (acc_kind == 2'b10)));
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (st_q != 2'b00));
  p_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == '0 && !acc_valid) |=> ((st_q & ~$past(st_q)) == 2'b00));
endmodule

bind prot_trap_unit prot_trap_unit_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .nmi_evt(nmi_evt),
  .bus_err_evt(bus_err_evt), .trap_req(trap_req), .trap_cause(trap_cause),
  .en_q(en_q), .inv_q(inv_q), .st_q(st_q), .hit(hit)
);

// File: tb/prot_trap_unit_tb_top.sv
`timescale 1ns/1ps
module prot_trap_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, acc_valid = 0, nmi_evt = 0, bus_err_evt = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, acc_addr = 0, reg_rdata;
  logic [1:0] acc_kind = 0;
  logic trap_req, trap_cause;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic m_en, m_inv;
  logic [1:0] m_st;
  logic [31:0] m_base [2];
  logic [31:0] m_mask [2];

  prot_trap_unit dut_i (.*);

  always #10 clk = ~clk;

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hits(input logic [31:0] a);
    for (int c = 0; c < 2; c++) exp_hits[c] = ((a ^ m_base[c]) & m_mask[c]) == 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: exp_read = {22'b0, m_inv, m_en, 6'b0, m_st};
      3'd1: exp_read = m_base[0];
      3'd2: exp_read = m_mask[0];
      3'd3: exp_read = m_base[1];
      3'd4: exp_read = m_mask[1];
      default: exp_read = 0;
    endcase
  endfunction

  task automatic cyc(input bit wr, input logic [2:0] sel, input logic [31:0] wd,
                     input bit av, input logic [31:0] a, input logic [1:0] k,
                     input bit nmi, input bit be, input string r);
    logic [1:0] h;
    bit fire, ereq;
    @(negedge clk);
    reg_we = wr; reg_sel = sel; reg_wdata = wd;
    acc_valid = av; acc_addr = a; acc_kind = k; nmi_evt = nmi; bus_err_evt = be;
    #2;
    h = exp_hits(a);
    fire = av && m_en && (m_inv ? ^h : |h);
    ereq = fire && !nmi && !be;
    check({r, " req"}, {31'b0, trap_req}, {31'b0, ereq});
    check({r, " cause"}, {31'b0, trap_cause}, {31'b0, ereq && k == 2'b10});
    @(posedge clk);
    #1;
    if (wr) begin
      case (sel)
        3'd0: begin m_en = wd[8]; m_inv = wd[9]; m_st = m_st & wd[1:0]; end
        3'd1: m_base[0] = wd;
        3'd2: m_mask[0] = wd;
        3'd3: m_base[1] = wd;
        3'd4: m_mask[1] = wd;
        default: ;
      endcase
    end
    if (fire) m_st = h;
    reg_we = 0; acc_valid = 0; nmi_evt = 0; bus_err_evt = 0;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] wd);
    cyc(1, sel, wd, 0, 0, 0, 0, 0, "R10 write");
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input string r);
    cyc(0, 0, 0, 1, a, k, 0, 0, r);
  endtask

  task automatic rd_chk(input logic [2:0] sel, input string r);
    @(negedge clk);
    reg_we = 0; reg_sel = sel;
    #2;
    check(r, reg_rdata, exp_read(sel));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_inv = 0; m_st = 0;
    for (int c = 0; c < 2; c++) begin m_base[c] = 0; m_mask[c] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int s = 0; s < 8; s++) rd_chk(3'(s), "R1/R10 reset read");
    acc(32'h1234_5678, 2'b01, "R5 disabled after reset");
    rd_chk(0, "R5 status frozen");

    wr_reg(1, 32'h1000_0000); wr_reg(2, 32'hF000_0000);
    wr_reg(3, 32'h1200_0000); wr_reg(4, 32'hFF00_0000);
    wr_reg(5, 32'hFFFF_FFFF);
    for (int s = 1; s < 8; s++) rd_chk(3'(s), "R10 base/mask read");

    wr_reg(0, 32'h0000_0100);
    acc(32'h1234_0000, 2'b01, "R3 both hit");
    rd_chk(0, "R6 status 11");
    acc(32'h1500_0000, 2'b00, "R3 ch0 only");
    rd_chk(0, "R6 status 01");
    acc(32'h2000_0000, 2'b10, "R2 no hit");
    rd_chk(0, "R6 status kept");
    cyc(0, 0, 0, 0, 32'h1234_0000, 2'b01, 0, 0, "R11 no strobe");

    wr_reg(0, 32'h0000_0303);
    rd_chk(0, "R10 ctrl unused bits 0");
    acc(32'h1234_0000, 2'b10, "R4 hole no trap");
    rd_chk(0, "R4 status unchanged");
    acc(32'h1500_0000, 2'b10, "R4 single hit store");
    acc(32'h1500_0000, 2'b00, "R8 fetch cause");
    acc(32'h1500_0000, 2'b11, "R8 kind 11 cause");

    wr_reg(0, 32'h0000_0100);
    acc(32'h1234_0000, 2'b01, "R7 set both");
    wr_reg(0, 32'h0000_0103);
    rd_chk(0, "R7 write 1 keeps");
    wr_reg(0, 32'h0000_0102);
    rd_chk(0, "R7 clear bit0 only");
    wr_reg(0, 32'h0000_0100);
    rd_chk(0, "R7 clear all");
    cyc(1, 0, 32'h0000_0100, 1, 32'h1500_0000, 2'b01, 0, 0, "R7 hw wins");
    rd_chk(0, "R7 hw wins status");

    cyc(0, 0, 0, 1, 32'h1234_0000, 2'b01, 1, 0, "R9 nmi");
    rd_chk(0, "R9 status under nmi");
    cyc(0, 0, 0, 1, 32'h1500_0000, 2'b10, 0, 1, "R9 bus error");
    rd_chk(0, "R9 status under bus error");

    wr_reg(0, 32'h0000_0003);
    acc(32'h1234_0000, 2'b01, "R5 disabled");
    rd_chk(0, "R5 status frozen");

    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 10;
      int c = $urandom % 2;
      logic [31:0] a;
      if (r == 0) begin
        wr_reg(3'($urandom % 5 == 0 ? 0 : 0), $urandom | 32'h0000_0100 & ($urandom % 4 == 0 ? 32'h0 : 32'hFFFF_FFFF));
      end else if (r == 1) begin
        logic [2:0] sel = 3'(1 + $urandom % 4);
        wr_reg(sel, sel[0] ? $urandom : ($urandom & 32'hFFF0_0000));
      end else if (r == 2) begin
        rd_chk(3'($urandom % 8), "R10 random read");
      end else begin
        a = $urandom;
        if ($urandom % 4 != 0) a = (m_base[c] & m_mask[c]) | (a & ~m_mask[c]);
        cyc(($urandom % 8) == 0, 0, $urandom, ($urandom % 8) != 0, a, 2'($urandom),
            ($urandom % 8) == 0, ($urandom % 10) == 0, "R2/R3/R4/R6 random");
      end
    end
    rd_chk(0, "R6 final status");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule